// File: doc/BRIEF.md
# Packed SIMD Lane Shifter

This block is a purely combinational shifter for packed data. It treats a 32-bit operand as four 8-bit lanes or as two 16-bit lanes and shifts every lane by the same amount. No bit ever crosses from one lane into the next. A 5-bit type code selects the lane width. A 2-bit kind field selects the shift: arithmetic right, logical right or logical left. The shift amount comes from a register operand or from an immediate, chosen by a select input.

A 2-bit mode field adjusts the shift. Mode 00 gives the plain shift. Mode 01 has a different meaning for each direction. On a right shift it rounds the result. On a left shift it saturates the result as a signed value and reports, lane by lane, which lanes were clamped. Some encodings are not defined: reserved type codes, mode 10 or 11, and kind 11. For any of these the block raises an illegal flag and drives a zero result.

The block sits in an execute stage, between operand selection and writeback. Because it holds no state, its result can be registered by whatever pipeline surrounds it.

Top module: `simd_lane_shifter`

## Requirements
- R1: Type codes 2 to 15 select four 8-bit lanes. Type codes 16 to 29 select two 16-bit lanes. Lane i occupies bits [i*W+W-1 : i*W] of both the operand and the result. The lane width W applies to every kind and every mode.
- R2: When `use_imm` is 1 the shift amount comes from `amt_imm`; when it is 0 it comes from `amt_reg`. With 16-bit lanes the amount is the low 4 bits of that source. With 8-bit lanes it is the low 3 bits, and bit 3 has no effect. An amount of zero leaves every lane unchanged.
- R3: With mode 00, kind 00 is an arithmetic right shift, kind 01 is a logical right shift and kind 10 is a logical left shift. Each lane is shifted on its own, and the same amount applies to all lanes.
- R4: With mode 01 and a right shift (kind 00 or 01), each lane equals its shifted value plus the last bit shifted out of that lane.
- R5: With mode 01 and kind 10, each lane is read as a signed value and shifted left. The lane is clamped when the exact result does not fit in W signed bits: a lane that was non-negative becomes the maximum (0x7F or 0x7FFF), and a lane that was negative becomes the minimum (0x80 or 0x8000). `sat` bit i is set exactly when lane i is clamped. With 16-bit lanes, `sat[3:2]` stay 0.
- R6: `sat` is all zero for every operation other than kind 10 with mode 01. This includes a mode 00 left shift that overflows.
- R7: `illegal` is 1 exactly when the type code is 0, 1, 30 or 31, when the mode is 10 or 11, or when the kind is 11. While it is 1, `result` and `sat` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src | input | 32 | Packed operand |
| amt_reg | input | 4 | Low bits of the register amount operand |
| amt_imm | input | 4 | Immediate shift amount |
| use_imm | input | 1 | 1 selects the immediate amount, 0 selects the register amount |
| kind | input | 2 | Shift kind: 00 arithmetic right, 01 logical right, 10 logical left |
| mode | input | 2 | 00 plain shift, 01 round (right shifts) or saturate (left shift) |
| type_code | input | 5 | Lane width code: 2 to 15 for 8-bit lanes, 16 to 29 for 16-bit lanes |
| result | output | 32 | Packed shifted result |
| sat | output | 4 | Per-lane saturation flags |
| illegal | output | 1 | Undefined encoding; result forced to zero |

## Verification
The embedded assertions check, whenever the inputs change, four properties that must always hold. An illegal encoding clears both the result and the flags. A saturation flag only appears for a saturating left shift. The upper two flags stay quiet with 16-bit lanes. A zero amount after masking passes the operand through unchanged. The assertions cannot show whether lane values are correct. That needs the bench's reference model, applied to directed cases (rounding of odd negative lanes, clamping in both directions, masking of bit 3 with 8-bit lanes, selection between immediate and register amounts) and to randomly drawn encodings.

// File: rtl/simd_lane_shifter.sv
module simd_lane_shifter #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 4
) (
  input  logic [DATA_W-1:0]   src,
  input  logic [AMT_W-1:0]    amt_reg,
  input  logic [AMT_W-1:0]    amt_imm,
  input  logic                use_imm,
  input  logic [1:0]          kind,
  input  logic [1:0]          mode,
  input  logic [4:0]          type_code,
  output logic [DATA_W-1:0]   result,
  output logic [DATA_W/8-1:0] sat,
  output logic                illegal
);
  localparam int N8  = DATA_W / 8;
  localparam int N16 = DATA_W / 16;

  logic [AMT_W-1:0] amt;
  logic narrow, wide, rnd, satm;

  assign amt     = use_imm ? amt_imm : amt_reg;
  assign narrow  = (type_code >= 5'd2)  && (type_code <= 5'd15);
  assign wide    = (type_code >= 5'd16) && (type_code <= 5'd29);
  assign illegal = !(narrow || wide) || mode[1] || (kind == 2'b11);
  assign rnd     = (mode == 2'b01) && (kind != 2'b10);
  assign satm    = (mode == 2'b01) && (kind == 2'b10);

  for (genvar g = 0; g < 2; g++) begin : gw
    localparam int W  = 8 << g;
    localparam int N  = DATA_W / W;
    localparam int SW = $clog2(W);
    logic [DATA_W-1:0] lres;
    logic [N8-1:0]     lsat;

    for (genvar l = 0; l < N; l++) begin : ln
      logic [W-1:0]   x, lr;
      logic [W:0]     rt;
      logic [2*W-1:0] lf;
      logic [SW-1:0]  sh;
      logic           ovf;

      assign x   = src[l*W +: W];
      assign sh  = amt[SW-1:0];
      assign lf  = {{W{x[W-1]}}, x} << sh;
      assign ovf = !(&lf[2*W-1:W-1]) && (|lf[2*W-1:W-1]);

      always_comb begin
        if (kind == 2'b00) rt = $signed({x, 1'b0}) >>> sh;
        else               rt = {x, 1'b0} >> sh;
        if (kind == 2'b10) begin
          if (satm && ovf) lr = x[W-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
          else             lr = lf[W-1:0];
        end else begin
          lr = rt[W:1] + {{(W-1){1'b0}}, rnd & rt[0]};
        end
      end

      assign lres[l*W +: W] = lr;
      assign lsat[l]        = satm && ovf;
    end

    if (N < N8) begin : pad
      assign lsat[N8-1:N] = '0;
    end
  end

  assign result = illegal ? '0 : (wide ? gw[1].lres : gw[0].lres);
  assign sat    = illegal ? '0 : (wide ? gw[1].lsat : gw[0].lsat);

  always_comb begin
    if (illegal)
      assert_illegal_clears_R7: assert (result == '0 && sat == '0);
    if (|sat)
      assert_sat_only_on_sll_R6: assert (!illegal && kind == 2'b10 && mode == 2'b01);
    if (wide)
      assert_sat_upper_quiet_R5: assert (sat[N8-1:N16] == '0);
    if (!illegal && ((wide && amt[3:0] == 4'd0) || (narrow && amt[2:0] == 3'd0)))
      assert_zero_amount_pass_R2: assert (result == src && sat == '0);
  end
endmodule

// File: tb/simd_lane_shifter_tb.sv
module simd_lane_shifter_tb;
  logic        clk = 1'b0;
  logic [31:0] src = '0;
  logic [3:0]  amt_reg = '0, amt_imm = '0;
  logic        use_imm = 1'b0;
  logic [1:0]  kind = '0, mode = '0;
  logic [4:0]  type_code = '0;
  logic [31:0] result;
  logic [3:0]  sat;
  logic        illegal;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  simd_lane_shifter u_dut (
    .src(src), .amt_reg(amt_reg), .amt_imm(amt_imm), .use_imm(use_imm),
    .kind(kind), .mode(mode), .type_code(type_code),
    .result(result), .sat(sat), .illegal(illegal)
  );

  function automatic void model(output logic [31:0] r, output logic [3:0] s, output logic il);
    int w, sh;
    longint mask, x, sx, v, hi, lo;
    r = '0; s = '0;
    il = !(type_code >= 2 && type_code <= 29) || mode[1] || kind == 2'b11;
    if (il) return;
    w  = (type_code >= 16) ? 16 : 8;
    sh = int'(use_imm ? amt_imm : amt_reg) % w;
    mask = (64'sd1 <<< w) - 1;
    hi = (64'sd1 <<< (w - 1)) - 1;
    lo = -(64'sd1 <<< (w - 1));
    for (int i = 0; i < 32 / w; i++) begin
      x  = longint'((src >> (i * w))) & mask;
      sx = (x > hi) ? x - (mask + 1) : x;
      case (kind)
        2'b00: begin
          v = sx >>> sh;
          if (mode == 2'b01 && sh > 0) v = v + ((sx >>> (sh - 1)) & 1);
        end
        2'b01: begin
          v = x >>> sh;
          if (mode == 2'b01 && sh > 0) v = v + ((x >>> (sh - 1)) & 1);
        end
        default: begin
          v = sx <<< sh;
          if (mode == 2'b01) begin
            if (v > hi) begin v = hi; s[i] = 1'b1; end
            else if (v < lo) begin v = lo; s[i] = 1'b1; end
          end
        end
      endcase
      r = r | (32'(v & mask) << (i * w));
    end
  endfunction

  task automatic apply(input logic [31:0] a, input logic [3:0] ar, input logic [3:0] ai,
                       input logic ui, input logic [1:0] k, input logic [1:0] m,
                       input logic [4:0] tc, input string tag);
    logic [31:0] er; logic [3:0] es; logic ei;
    @(posedge clk);
    src = a; amt_reg = ar; amt_imm = ai; use_imm = ui; kind = k; mode = m; type_code = tc;
    @(negedge clk);
    model(er, es, ei);
    checks++;
    if (result !== er || sat !== es || illegal !== ei) begin
      fails++;
      $display("FAIL %s: result=%h sat=%b illegal=%b expected result=%h sat=%b illegal=%b",
               tag, result, sat, illegal, er, es, ei);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    checks++;
    if (result !== 32'h0 || sat !== 4'h0 || illegal !== 1'b1) begin
      fails++;
      $display("FAIL R7 idle: result=%h sat=%b illegal=%b expected 0 0 1", result, sat, illegal);
    end
    apply(32'h12345678, 4'd4, 4'd0, 1'b0, 2'b01, 2'b00, 5'd16, "R1 wide srl");
    apply(32'h12345678, 4'd4, 4'd0, 1'b0, 2'b01, 2'b00, 5'd2,  "R1 narrow srl");
    apply(32'h80F00F08, 4'd3, 4'd0, 1'b0, 2'b00, 2'b00, 5'd29, "R1 wide sra");
    apply(32'h80F00F08, 4'd3, 4'd0, 1'b0, 2'b00, 2'b00, 5'd15, "R1 narrow sra");
    apply(32'hA5C3_7E81, 4'd9, 4'd1, 1'b0, 2'b00, 2'b00, 5'd5, "R2 bit3 masked narrow");
    apply(32'hA5C3_7E81, 4'd8, 4'd0, 1'b0, 2'b10, 2'b01, 5'd7, "R2 amount zero passes");
    apply(32'hA5C3_7E81, 4'd1, 4'd6, 1'b1, 2'b10, 2'b00, 5'd20, "R2 immediate select");
    apply(32'hA5C3_7E81, 4'd6, 4'd1, 1'b0, 2'b10, 2'b00, 5'd20, "R2 register select");
    apply(32'h0F0F_F0F0, 4'd2, 4'd0, 1'b0, 2'b10, 2'b00, 5'd3, "R3 sll lanes isolated");
    apply(32'hFD03_FD03, 4'd1, 4'd0, 1'b0, 2'b00, 2'b01, 5'd9, "R4 round sra narrow");
    apply(32'hFFFF_0003, 4'd1, 4'd0, 1'b0, 2'b01, 2'b01, 5'd17, "R4 round srl wide");
    apply(32'h8001_7FFF, 4'd15, 4'd0, 1'b0, 2'b00, 2'b01, 5'd18, "R4 round max amount");
    apply(32'h4000_C000, 4'd1, 4'd0, 1'b0, 2'b10, 2'b01, 5'd16, "R5 sat positive wide");
    apply(32'h4080_BF7F, 4'd1, 4'd0, 1'b0, 2'b10, 2'b01, 5'd16, "R5 sat both wide");
    apply(32'h40C0_8001, 4'd1, 4'd0, 1'b0, 2'b10, 2'b01, 5'd12, "R5 sat narrow");
    apply(32'h4000_C000, 4'd3, 4'd0, 1'b0, 2'b10, 2'b00, 5'd16, "R6 plain sll no flag");
    apply(32'h7F7F_8080, 4'd3, 4'd0, 1'b0, 2'b00, 2'b01, 5'd4, "R6 round no flag");
    apply(32'hFFFF_FFFF, 4'd1, 4'd0, 1'b0, 2'b10, 2'b01, 5'd30, "R7 reserved type");
    apply(32'hFFFF_FFFF, 4'd1, 4'd0, 1'b0, 2'b10, 2'b10, 5'd16, "R7 reserved mode");
    apply(32'hFFFF_FFFF, 4'd1, 4'd0, 1'b0, 2'b11, 2'b00, 5'd16, "R7 reserved kind");
    for (int n = 0; n < 3000; n++) begin
      logic [1:0] k, m; logic [4:0] tc; string tag;
      k  = 2'($urandom_range(0, 3));
      m  = ($urandom_range(0, 7) == 0) ? 2'($urandom_range(2, 3)) : 2'($urandom_range(0, 1));
      tc = 5'($urandom_range(0, 31));
      if (tc < 2 || tc > 29 || m[1] || k == 2'b11) tag = "R7 random";
      else if (k == 2'b10 && m == 2'b01) tag = "R5 random";
      else if (m == 2'b01) tag = "R4 random";
      else tag = "R3 random";
      apply($urandom, 4'($urandom), 4'($urandom), 1'($urandom), k, m, tc, tag);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule